// File: doc/BRIEF.md
# Priority Interrupt Controller with Mask Compare

This block collects one nonmaskable request line, a set of external maskable request lines and a group of on-chip peripheral request lines, and turns them into a single registered request to a CPU. Each request carries a 12-bit event code that names its source. Software sets a 4-bit priority level for each source, or for a group of sources, through a small register port. The controller picks the winning request and compares its level with the CPU's current 4-bit mask value, which arrives as an input. It raises the CPU request only when that level is strictly higher than the mask. The nonmaskable line bypasses the comparison.

The peripheral group is split across two priority fields. A system-error source has a field of its own. Seven other sources share a second field, and a fixed order decides among them. Once the request is raised, the request and its code stay frozen until the CPU pulses an acknowledge. The mask is only ever read: the controller has no path that writes it. Sources are level lines that the CPU services, so a request still present after an acknowledge is raised again.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset `irq_o` is 0, `code_o` is 0x000 and both priority registers read back 0.
- R2: A write with `reg_wr_i`=1 stores `reg_wdata_i` into register `reg_addr_i` at the clock edge. `reg_rdata_o` always shows the register selected by `reg_addr_i`.
- R3: A maskable source whose priority field is 0 never raises the request, whatever the mask is.
- R4: A maskable winner is accepted only when its level is strictly greater than `imask_i`. An equal or lower level leaves `irq_o` at 0.
- R5: `nmi_i` is accepted whatever the mask is, even at 15. It beats every other source and reports code 0x1C0.
- R6: Among maskable sources the highest level wins. External line i has code 0x200+0x20*i, the system-error source has code 0xA00, and group bit k has code 0xA20+0x20*k.
- R7: When different fields carry equal levels, the fixed order ext0, ext1, ext2, ext3, system error, group decides, with the earlier one winning.
- R8: Within the group (bit 0 error, bit 1 power-down, bit 2 power-on, bits 3..6 DMA channels 0..3), the set bit with the highest index wins.
- R9: `irq_o` rises, and `code_o` is loaded with the winner's code, on the first clock edge at which an accepted request is present.
- R10: While `irq_o` is 1, `irq_o` and `code_o` hold their values until a clock edge with `ack_i`=1. `irq_o` is 0 after that edge.
- R11: Field layout: register 0 bits 3:0 hold the system-error level and bits 7:4 hold the group level. Register 1 bits 4i+3:4i hold the level of external line i. Register 0 bits 15:8 are stored but have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Nonmaskable request |
| ext_req_i | input | 4 | External maskable request lines |
| sys_err_req_i | input | 1 | Peripheral system-error request |
| grp_req_i | input | 7 | Peripheral group requests, shared priority field |
| imask_i | input | 4 | CPU mask level, read only |
| ack_i | input | 1 | CPU acknowledge pulse |
| reg_wr_i | input | 1 | Priority register write enable |
| reg_addr_i | input | 1 | Priority register select |
| reg_wdata_i | input | 16 | Priority register write data |
| reg_rdata_o | output | 16 | Priority register read data |
| irq_o | output | 1 | Registered request to the CPU |
| code_o | output | 12 | Event code of the raised request |

## Verification
Two things can land in the same cycle. A held request may be waiting for its acknowledge when a new, higher-priority request or a change of mask arrives. The acknowledge may also coincide with requests that are still pending. The bench provokes the first case by drawing fresh random requests while `irq_o` is high, and checks that `code_o` stays frozen. It provokes the second by pulsing `ack_i` while those requests remain driven, and checks that `irq_o` drops at that edge before any new arbitration.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int LVL_W  = 4;
  localparam int CODE_W = 12;
  localparam int DATA_W = 16;
  localparam int GRP_N  = 7;
  localparam logic [CODE_W-1:0] NMI_CODE  = 12'h1C0;
  localparam logic [CODE_W-1:0] EXT_BASE  = 12'h200;
  localparam logic [CODE_W-1:0] SYS_CODE  = 12'hA00;
  localparam logic [CODE_W-1:0] GRP_BASE  = 12'hA20;
  localparam int                CODE_STEP = 32;
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_prio_pkg::*;
#(
  parameter int NUM_REGS = 2,
  localparam int ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DATA_W-1:0]            rdata_o,
  output logic [NUM_REGS*DATA_W-1:0]   prio_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [DATA_W-1:0] regs_d [NUM_REGS];

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      regs_d[i] = regs_q[i];
    end
    if (wr_i) regs_d[addr_i] = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else if (wr_i) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= regs_d[i];
    end
  end

  assign rdata_o = regs_q[addr_i];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign prio_o[g*DATA_W +: DATA_W] = regs_q[g];
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_prio_pkg::*;
#(
  parameter int NUM_EXT = 4,
  localparam int NCAND  = NUM_EXT + 3
) (
  input  logic                     nmi_i,
  input  logic [NUM_EXT-1:0]       ext_req_i,
  input  logic                     sys_req_i,
  input  logic [GRP_N-1:0]         grp_req_i,
  input  logic [2*DATA_W-1:0]      prio_i,
  input  logic [LVL_W-1:0]         mask_i,
  output logic                     accept_o,
  output logic [LVL_W:0]           win_lvl_o,
  output logic [CODE_W-1:0]        win_code_o
);
  logic [NCAND-1:0]  c_vld;
  logic [LVL_W:0]    c_lvl  [NCAND];
  logic [CODE_W-1:0] c_code [NCAND];
  logic [CODE_W-1:0] grp_code;
  logic              unused_rsvd;

  assign unused_rsvd = ^prio_i[DATA_W-1:8] ^ ^prio_i[2*DATA_W-1:DATA_W+4*NUM_EXT];

  // candidate 0: nonmaskable, level above any mask
  assign c_vld[0]  = nmi_i;
  assign c_lvl[0]  = {1'b1, {LVL_W{1'b0}}};
  assign c_code[0] = NMI_CODE;

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
    assign c_vld[1+g]  = ext_req_i[g];
    assign c_lvl[1+g]  = {1'b0, prio_i[DATA_W + 4*g +: LVL_W]};
    assign c_code[1+g] = EXT_BASE + 12'(g * CODE_STEP);
  end

  assign c_vld[NUM_EXT+1]  = sys_req_i;
  assign c_lvl[NUM_EXT+1]  = {1'b0, prio_i[3:0]};
  assign c_code[NUM_EXT+1] = SYS_CODE;

  // fixed order inside the shared field: highest bit wins
  always_comb begin
    grp_code = GRP_BASE;
    for (int k = 0; k < GRP_N; k++) begin
      if (grp_req_i[k]) grp_code = GRP_BASE + 12'(k * CODE_STEP);
    end
  end

  assign c_vld[NUM_EXT+2]  = |grp_req_i;
  assign c_lvl[NUM_EXT+2]  = {1'b0, prio_i[7:4]};
  assign c_code[NUM_EXT+2] = grp_code;

  // strict compare keeps the lower index on ties; level 0 never wins
  always_comb begin
    win_lvl_o  = '0;
    win_code_o = '0;
    for (int i = 0; i < NCAND; i++) begin
      if (c_vld[i] && (c_lvl[i] > win_lvl_o)) begin
        win_lvl_o  = c_lvl[i];
        win_code_o = c_code[i];
      end
    end
  end

  assign accept_o = win_lvl_o > {1'b0, mask_i};
endmodule

// File: rtl/irq_prio_out.sv
module irq_prio_out
  import irq_prio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [CODE_W-1:0] code_o
);
  logic              irq_q, irq_d;
  logic [CODE_W-1:0] code_q;
  logic              code_en;

  always_comb begin
    irq_d   = irq_q;
    code_en = 1'b0;
    if (!irq_q) begin
      if (accept_i) begin
        irq_d   = 1'b1;
        code_en = 1'b1;
      end
    end else if (ack_i) begin
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_en) code_q <= code_i;
  end

  assign irq_o  = irq_q;
  assign code_o = code_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM_EXT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_i,
  input  logic [NUM_EXT-1:0] ext_req_i,
  input  logic              sys_err_req_i,
  input  logic [GRP_N-1:0]  grp_req_i,
  input  logic [LVL_W-1:0]  imask_i,
  input  logic              ack_i,
  input  logic              reg_wr_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int NUM_REGS = 2;

  logic [NUM_REGS*DATA_W-1:0] prio;
  logic                       accept;
  logic [LVL_W:0]             win_lvl;
  logic [CODE_W-1:0]          win_code;

  irq_prio_regs #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .prio_o(prio)
  );

  irq_prio_arb #(.NUM_EXT(NUM_EXT)) u_arb (
    .nmi_i(nmi_i), .ext_req_i(ext_req_i), .sys_req_i(sys_err_req_i),
    .grp_req_i(grp_req_i), .prio_i(prio), .mask_i(imask_i),
    .accept_o(accept), .win_lvl_o(win_lvl), .win_code_o(win_code)
  );

  irq_prio_out u_out (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .code_i(win_code),
    .ack_i(ack_i), .irq_o(irq_o), .code_o(code_o)
  );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        nmi_i,
  input logic [3:0]  mask_i,
  input logic        ack_i,
  input logic        irq_o,
  input logic [11:0] code_o,
  input logic [4:0]  win_lvl
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ack_i) |=> (irq_o && $stable(code_o)));

  p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && ack_i) |=> !irq_o);

  p_nmi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && nmi_i) |=> (irq_o && code_o == 12'h1C0));

  p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(nmi_i) || ($past(win_lvl) > {1'b0, $past(mask_i)})));

  p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !nmi_i && win_lvl == 5'd0) |=> !irq_o);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .mask_i(imask_i), .ack_i(ack_i),
  .irq_o(irq_o), .code_o(code_o), .win_lvl(win_lvl)
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        nmi;
  logic [3:0]  ext;
  logic        sys;
  logic [6:0]  grp;
  logic [3:0]  mask;
  logic        ack;
  logic        wr;
  logic        addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        irq;
  logic [11:0] code;

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] sh0, sh1;

  always #10 clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi), .ext_req_i(ext), .sys_err_req_i(sys),
    .grp_req_i(grp), .imask_i(mask), .ack_i(ack), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .code_o(code)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected {accept, code} from the requirements
  function automatic logic [12:0] model();
    logic [4:0]  bl;
    logic [11:0] bc;
    if (nmi) return {1'b1, 12'h1C0};
    bl = 0; bc = 0;
    for (int i = 0; i < 4; i++)
      if (ext[i] && {1'b0, sh1[4*i +: 4]} > bl) begin
        bl = {1'b0, sh1[4*i +: 4]}; bc = 12'h200 + 12'(32*i);
      end
    if (sys && {1'b0, sh0[3:0]} > bl) begin bl = {1'b0, sh0[3:0]}; bc = 12'hA00; end
    if (grp != 0 && {1'b0, sh0[7:4]} > bl) begin
      bl = {1'b0, sh0[7:4]};
      for (int k = 0; k < 7; k++) if (grp[k]) bc = 12'hA20 + 12'(32*k);
    end
    return {(bl > {1'b0, mask}), bc};
  endfunction

  task automatic wreg(input logic a, input logic [15:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
    if (a) sh1 = d; else sh0 = d;
  endtask

  task automatic clr_req();
    nmi = 0; ext = 0; sys = 0; grp = 0;
  endtask

  // requests are already driven; one edge later compare, then acknowledge
  task automatic step(input string tag);
    logic [12:0] e;
    logic [11:0] held;
    e = model();
    @(negedge clk);
    chk(irq == e[12], tag, irq, e[12]);
    if (e[12]) chk(code == e[11:0], tag, code, e[11:0]);
    if (irq) begin
      held = code;
      nmi = 1'($urandom); ext = 4'($urandom); sys = 1'($urandom); grp = 7'($urandom);
      mask = 4'($urandom);
      @(negedge clk);
      chk(irq == 1 && code == held, "R10 hold", code, held);
      ack = 1;
      @(negedge clk);
      ack = 0;
      chk(irq == 0, "R10 drop", irq, 0);
    end
    clr_req();
    @(negedge clk);
    if (irq) begin ack = 1; @(negedge clk); ack = 0; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rst_n = 0; clr_req(); mask = 0; ack = 0; wr = 0; addr = 0; wdata = 0;
    sh0 = 0; sh1 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(irq == 0, "R1 irq", irq, 0);
    chk(code == 0, "R1 code", code, 0);
    addr = 0; #1 chk(rdata == 0, "R1 reg0", rdata, 0);
    addr = 1; #1 chk(rdata == 0, "R1 reg1", rdata, 0);

    // R3: all levels 0, mask 0
    ext = 4'hF; sys = 1; grp = 7'h7F; mask = 0;
    step("R3 level0");

    wreg(0, 16'hAB35);
    wreg(1, 16'h7531);
    @(negedge clk); addr = 0; #1 chk(rdata == 16'hAB35, "R2 rd0", rdata, 16'hAB35);
    addr = 1; #1 chk(rdata == 16'h7531, "R2 rd1", rdata, 16'h7531);

    // R4: ext2 level 5, mask equal then one below
    ext = 4'b0100; mask = 5; step("R4 equal");
    ext = 4'b0100; mask = 4; step("R4 above");
    // R5: NMI with full mask
    nmi = 1; ext = 4'hF; mask = 15; step("R5 nmi");
    // R11/R6: group level 3, sys level 5, mask 0
    grp = 7'h01; sys = 1; mask = 0; step("R6 sys wins");
    // R8: group bits 1 and 6
    grp = 7'b1000010; mask = 2; step("R8 group order");
    // R7: tie between ext0 (1) and ... set equal levels
    wreg(1, 16'h0444); wreg(0, 16'h0044);
    ext = 4'b0110; sys = 1; grp = 7'h10; mask = 0; step("R7 tie ext");
    sys = 1; grp = 7'h10; mask = 3; step("R7 tie sys");
    // R11: upper bits of reg0 have no effect
    wreg(0, 16'hFF00); sys = 1; grp = 7'h7F; step("R11 rsvd");
    // R9 random mix
    for (int t = 0; t < 400; t++) begin
      wreg(0, 16'($urandom));
      wreg(1, 16'($urandom));
      nmi = (($urandom % 8) == 0); ext = 4'($urandom); sys = 1'($urandom);
      grp = 7'($urandom); mask = 4'($urandom % 12);
      step("R9 random");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule